// File: doc/BRIEF.md
# Dual-Rate Width-Matching FIFO Port

This block sits between an external data bus and the internal FIFO, on both the write side and the read side. Each external beat is 10 or 20 bits wide. The internal FIFO word is 40 bits, made of four 10-bit lanes. Beats move on the rising edge only (single rate) or on both clock edges (double rate).

The mode is taken from two configuration pins while master reset is held low. It then stays fixed until the next master reset.

On the write side, beats are packed into FIFO words, lowest lane first, and each finished word is handed over as a one-cycle put. On the read side, FIFO words are taken when needed and split into beats in the same lane order. An echo clock and an echo enable are driven next to the data, so the receiver can capture each beat.

Top module: `ddr_bus_match_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block samples `cfg_ddr` (1 = double rate) and `cfg_wide` (1 = 20-bit beats) and clears all packing and serializing state. During reset, `wr_put`, `echo_en` and `rd_take` stay low. After reset, changes on the configuration pins have no effect until the next reset.
- R2: For 10-bit beats only `din[9:0]` is used and `din[19:10]` is ignored. A 20-bit beat supplies two lanes: bits 9:0 first, then bits 19:10.
- R3: In single rate, a beat is taken at each rising edge where `wen` is high, and falling edges carry no data.
- R4: In double rate, a beat is also taken at each falling edge where `wen` is high. An edge where `wen` is sampled low transfers nothing.
- R5: Lanes fill the 40-bit word from bit 0 upward, in arrival order. A falling-edge beat comes before the beat of the rising edge that follows it. At the rising edge that completes four lanes, `wr_word` and a one-cycle `wr_put` are registered, and any surplus lanes start the next word.
- R6: At a rising edge with `ren` high, the output sends lanes lowest first if any lanes remain or `rd_avail` is high. In single rate one beat goes out per cycle. In double rate the rising-edge beat precedes the falling-edge beat. `rd_take` is high exactly when `ren`, `rd_avail` and no remaining lanes coincide, and the word is consumed at that edge.
- R7: `echo_clk` follows `clk`. `echo_en` is high for each half cycle (double rate) or whole cycle (single rate) in which `dout` carries a valid beat.
- R8: For 10-bit beats, `dout[19:10]` is zero.
- R9: A rising edge with `ren` low sends no beat, takes no word and keeps the remaining lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; both edges used in double rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_ddr | input | 1 | Double-rate select, sampled during reset |
| cfg_wide | input | 1 | 20-bit beat select, sampled during reset |
| wen | input | 1 | Write enable, sampled on every active edge |
| din | input | 20 | Write beat |
| wr_put | output | 1 | Completed FIFO word valid |
| wr_word | output | 40 | Completed FIFO word |
| ren | input | 1 | Read enable, sampled on rising edges |
| rd_avail | input | 1 | FIFO has a word ready |
| rd_word | input | 40 | Head word of the FIFO |
| rd_take | output | 1 | Consume the head word at this edge |
| dout | output | 20 | Read beat |
| echo_en | output | 1 | Read beat valid |
| echo_clk | output | 1 | Forwarded clock |

## Verification
The hardest case to reach is a 10-bit double-rate stream in which the falling-edge and rising-edge enables vary on their own. This leaves one to three lanes carried across a word boundary, with a held falling beat waiting at the same time. The stimulus draws a separate random enable for every half cycle, at several densities, and runs all four mode combinations. The configuration pins are also scrambled on every cycle after reset, so that any use of them outside reset shows up in the data.

// File: rtl/ddr_bus_match_port.sv
module ddr_bus_match_port #(
  parameter int LANE  = 10,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_ddr,
  input  logic                  cfg_wide,
  input  logic                  wen,
  input  logic [2*LANE-1:0]     din,
  output logic                  wr_put,
  output logic [LANES*LANE-1:0] wr_word,
  input  logic                  ren,
  input  logic                  rd_avail,
  input  logic [LANES*LANE-1:0] rd_word,
  output logic                  rd_take,
  output logic [2*LANE-1:0]     dout,
  output logic                  echo_en,
  output logic                  echo_clk
);
  localparam int BW = 2*LANE;
  localparam int WW = LANES*LANE;
  localparam int AW = (LANES-1)*LANE;
  localparam int XW = AW + 2*BW;
  localparam int CW = $clog2(LANES+1);

  function automatic logic [BW-1:0] trim(input logic [BW-1:0] v, input logic wide);
    return wide ? v : {{(BW-LANE){1'b0}}, v[LANE-1:0]};
  endfunction

  logic ddr_q, wide_q;
  logic [CW-1:0] k, cap;
  assign k   = wide_q ? CW'(2) : CW'(1);
  assign cap = ddr_q ? (k << 1) : k;

  // write side: falling-edge holding register
  logic fv;
  logic [BW-1:0] fd;
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      fv <= 1'b0;
      fd <= '0;
    end else begin
      fv <= ddr_q & wen;
      fd <= din;
    end
  end

  // write side: lane accumulator
  logic [CW-1:0] cnt, nb;
  logic [CW:0] total;
  logic [AW-1:0] acc;
  logic [BW-1:0] rbeat;
  logic [2*BW-1:0] fresh;
  logic [XW-1:0] ext;

  assign rbeat = wen ? trim(din, wide_q) : '0;
  assign nb    = (fv ? k : '0) + (wen ? k : '0);
  assign fresh = fv ? ({{BW{1'b0}}, trim(fd, wide_q)} | ({{BW{1'b0}}, rbeat} << (k*LANE)))
                    : {{BW{1'b0}}, rbeat};
  assign ext   = {{(2*BW){1'b0}}, acc} | ({{AW{1'b0}}, fresh} << (cnt*LANE));
  assign total = {1'b0, cnt} + {1'b0, nb};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q   <= cfg_ddr;
      wide_q  <= cfg_wide;
      cnt     <= '0;
      acc     <= '0;
      wr_put  <= 1'b0;
      wr_word <= '0;
    end else if (total >= (CW+1)'(LANES)) begin
      wr_put  <= 1'b1;
      wr_word <= ext[WW-1:0];
      acc     <= ext[WW +: AW];
      cnt     <= CW'(total - (CW+1)'(LANES));
    end else begin
      wr_put  <= 1'b0;
      acc     <= ext[AW-1:0];
      cnt     <= total[CW-1:0];
    end
  end

  // read side: serializer
  logic [CW-1:0] scnt;
  logic [WW-1:0] sbuf, src;
  logic go, lo;
  logic rise_v, fall_v;
  logic [BW-1:0] rise_d, fall_d;

  assign src     = (scnt == '0) ? rd_word : sbuf;
  assign rd_take = rst_n & ren & rd_avail & (scnt == '0);
  assign go      = rst_n & ren & (rd_avail | (scnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt   <= '0;
      sbuf   <= '0;
      rise_v <= 1'b0;
      fall_v <= 1'b0;
      rise_d <= '0;
      fall_d <= '0;
    end else if (go) begin
      rise_v <= 1'b1;
      rise_d <= trim(src[BW-1:0], wide_q);
      fall_v <= ddr_q;
      fall_d <= trim(BW'(src >> (k*LANE)), wide_q);
      sbuf   <= src >> (cap*LANE);
      scnt   <= ((scnt == '0) ? CW'(LANES) : scnt) - cap;
    end else begin
      rise_v <= 1'b0;
      fall_v <= 1'b0;
    end
  end

  assign lo       = ddr_q & ~clk;
  assign dout     = lo ? fall_d : rise_d;
  assign echo_en  = lo ? fall_v : rise_v;
  assign echo_clk = clk;
endmodule

module ddr_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ddr_q,
  input logic wide_q,
  input logic wr_put,
  input logic rd_take,
  input logic scnt_idle,
  input logic ren,
  input logic rise_v,
  input logic fall_v
);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(ddr_q) && $stable(wide_q)));
  // R3
  sdr_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_q |-> !fall_v);
  // R5
  narrow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ddr_q && !wide_q && wr_put) |=> !wr_put);
  // R6
  take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scnt_idle |-> !rd_take);
  // R7
  take_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rise_v);
  // R9
  ren_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !rise_v);
endmodule

bind ddr_bus_match_port ddr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_q(ddr_q), .wide_q(wide_q), .wr_put(wr_put),
  .rd_take(rd_take), .scnt_idle(scnt == '0), .ren(ren), .rise_v(rise_v), .fall_v(fall_v)
);

// File: tb/tb_ddr_bus_match_port.sv
module tb_ddr_bus_match_port;
  localparam int BW = 20;
  localparam int WW = 40;

  logic clk = 1'b0, rst_n = 1'b0, cfg_ddr = 1'b0, cfg_wide = 1'b0;
  logic wen = 1'b0, ren = 1'b0, rd_avail = 1'b0;
  logic [BW-1:0] din = '0;
  logic [WW-1:0] rd_word = '0;
  logic wr_put, rd_take, echo_en, echo_clk;
  logic [WW-1:0] wr_word;
  logic [BW-1:0] dout;

  always #4 clk = ~clk;

  ddr_bus_match_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .cfg_wide(cfg_wide),
    .wen(wen), .din(din), .wr_put(wr_put), .wr_word(wr_word),
    .ren(ren), .rd_avail(rd_avail), .rd_word(rd_word), .rd_take(rd_take),
    .dout(dout), .echo_en(echo_en), .echo_clk(echo_clk)
  );

  int total = 0, failed = 0;
  int p_wen = 0, p_ren = 0, p_avail = 0;
  bit scramble = 0, m_ddr = 0, m_wide = 0, last_ren = 0;

  logic [WW-1:0] srcq[$];
  logic [9:0] inq[$];
  logic [9:0] outq[$];
  bit fp_v = 0, exp_put = 0, er_v = 0, ef_v = 0;
  logic [BW-1:0] fp_d = '0, er_d = '0, ef_d = '0;
  logic [WW-1:0] exp_word = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic push_lanes(input logic [BW-1:0] d, input int k);
    for (int j = 0; j < k; j++) inq.push_back(d[j*10 +: 10]);
  endtask

  function automatic logic [BW-1:0] take_beat(input int k);
    logic [BW-1:0] v = '0;
    for (int j = 0; j < k; j++) v[j*10 +: 10] = outq.pop_front();
    return v;
  endfunction

  // stimulus for the falling edge
  always @(posedge clk) begin
    #2;
    wen = ($urandom % 100) < p_wen;
    din = BW'($urandom);
  end

  // stimulus for the rising edge
  always @(negedge clk) begin
    #2;
    wen = ($urandom % 100) < p_wen;
    din = BW'($urandom);
    ren = ($urandom % 100) < p_ren;
    if (srcq.size() < 3 && ($urandom % 100) < p_avail)
      srcq.push_back({$urandom, $urandom});
    rd_avail = srcq.size() > 0;
    rd_word  = (srcq.size() > 0) ? srcq[0] : {$urandom, $urandom};
    if (scramble && rst_n) begin
      cfg_ddr  = $urandom % 2;
      cfg_wide = $urandom % 2;
    end
  end

  // reference model, rising edge
  always @(posedge clk) begin
    int k;
    k = m_wide ? 2 : 1;
    if (!rst_n) begin
      m_ddr = cfg_ddr;
      m_wide = cfg_wide;
      inq.delete();
      outq.delete();
      exp_put = 0;
      er_v = 0;
      ef_v = 0;
    end else begin
      if (fp_v) push_lanes(fp_d, k);
      if (wen) push_lanes(din, k);
      exp_put = inq.size() >= 4;
      if (exp_put)
        for (int j = 0; j < 4; j++) exp_word[j*10 +: 10] = inq.pop_front();
      if (ren && (outq.size() > 0 || rd_avail)) begin
        if (outq.size() == 0) begin
          for (int j = 0; j < 4; j++) outq.push_back(rd_word[j*10 +: 10]);
          void'(srcq.pop_front());
        end
        er_v = 1;
        er_d = take_beat(k);
        ef_v = m_ddr;
        if (m_ddr) ef_d = take_beat(k);
      end else begin
        er_v = 0;
        ef_v = 0;
      end
    end
    last_ren = ren;
    #1;
    chk(wr_put === exp_put, rst_n ? "R5 put" : "R1 put in reset", 64'(wr_put), 64'(exp_put));
    if (exp_put)
      chk(wr_word === exp_word,
          $sformatf("R5 word (%s, %s)", m_ddr ? "R4" : "R3", m_wide ? "wide" : "R2 narrow"),
          64'(wr_word), 64'(exp_word));
    chk(echo_en === er_v, !rst_n ? "R1 echo in reset" : (last_ren ? "R7 rise echo" : "R9 ren low"),
        64'(echo_en), 64'(er_v));
    if (er_v) chk(dout === er_d, "R6 rise beat", 64'(dout), 64'(er_d));
    if (er_v && !m_wide) chk(dout[19:10] === 10'd0, "R8 upper zero", 64'(dout[19:10]), 64'd0);
    chk(echo_clk === 1'b1, "R7 echo clk high", 64'(echo_clk), 64'd1);
  end

  // reference model, falling edge
  always @(negedge clk) begin
    if (!rst_n) fp_v = 0;
    else begin
      fp_v = m_ddr && wen;
      fp_d = din;
    end
    #1;
    chk(echo_clk === 1'b0, "R7 echo clk low", 64'(echo_clk), 64'd0);
    if (m_ddr) begin
      chk(echo_en === ef_v, "R4 fall echo", 64'(echo_en), 64'(ef_v));
      if (ef_v) chk(dout === ef_d, "R6 fall beat", 64'(dout), 64'(ef_d));
    end else begin
      chk(echo_en === er_v, "R3 sdr echo hold", 64'(echo_en), 64'(er_v));
      if (er_v) chk(dout === er_d, "R3 sdr beat hold", 64'(dout), 64'(er_d));
    end
    #2;
    chk(rd_take === (rst_n && ren && rd_avail && outq.size() == 0), "R6 take",
        64'(rd_take), 64'(rst_n && ren && rd_avail && outq.size() == 0));
  end

  task automatic run_mode(input bit d, input bit w, input int pw, input int pr, input int pa, input int cycles);
    @(negedge clk);
    #1 scramble = 0;
    #1;
    cfg_ddr = d;
    cfg_wide = w;
    rst_n = 0;
    p_wen = pw;
    p_ren = pr;
    p_avail = pa;
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    #1 scramble = 1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      run_mode(m[1], m[0], 100, 100, 100, 60);
      run_mode(m[1], m[0], 50, 50, 60, 250);
      run_mode(m[1], m[0], 20, 80, 30, 120);
      run_mode(m[1], m[0], 0, 0, 100, 20);
    end
    run_mode(1, 0, 70, 40, 80, 300);
    scramble = 0;
    finish_run();
  end
endmodule